// File: doc/BRIEF.md
# Status Register with Block Write Protection

This block keeps the 8-bit status byte of a serial memory device and decides, for any memory address, whether a write there may proceed. The byte holds a write enable latch and a 2-bit protect field; the remaining five bits are hard-wired and cannot be changed by any command. An upstream command decoder presents one decoded operation per clock while the chip select is low. The operations are:

- set the latch
- clear the latch
- read the status
- write the status
- signal a memory write

The block watches the chip select for the end of each transaction. After any transaction that carried a write, it drops the latch, so that every write needs a fresh enable.

The memory size is a parameter, given as an address width. The protect field marks a region at the top of the memory as read-only. That region can be empty, the upper quarter, the upper half or the whole array. The permit output combines the current latch state, the protect field and the address presented on the query port. The memory array uses it to gate its write strobe.

Top module: `sps_status_guard`

## Requirements
- R1: After reset the status byte reads 8'h40 (latch clear, protect field 00) and the permit output is 0.
- R2: Status bits 7, 5, 4 and 0 always read 0 and bit 6 always reads 1, whatever data a status write carries.
- R3: The set-latch operation (cmd_op = 1) makes status bit 1 read 1 from the next clock edge on.
- R4: The clear-latch operation (cmd_op = 2) makes status bit 1 read 0 from the next clock edge on.
- R5: A status write (cmd_op = 4) copies wr_data[3:2] into status bits 3:2 at the next edge only while bit 1 is set; while bit 1 is clear the write changes nothing.
- R6: A status write never changes bit 1, whatever value wr_data[1] carries.
- R7: At the first clock edge where cs_n is high after being low, bit 1 clears if, during that low period, either an accepted status write or a memory write (cmd_op = 5) was issued while bit 1 was set; otherwise bit 1 keeps its value.
- R8: With ADDR_W address bits and protect field P = status[3:2], the protected addresses are none for P=00, those with the top two address bits 11 for P=01, those with the top address bit 1 for P=10, and all for P=11; permit is 0 for a protected address.
- R9: Permit is 1 only while status bit 1 is set and the address on mem_addr is outside the protected region; it follows mem_addr without a clock delay.
- R10: Operations presented while cs_n is high, the read-status operation (cmd_op = 3), and unused codes (0, 6, 7) leave the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; its rising edge ends a transaction |
| cmd_valid | input | 1 | A decoded operation is present this cycle |
| cmd_op | input | 3 | Operation code (1 set, 2 clear, 3 read, 4 status write, 5 memory write) |
| wr_data | input | 8 | Data byte for a status write |
| mem_addr | input | ADDR_W | Address whose write permission is queried |
| status_o | output | 8 | Current status byte |
| permit_o | output | 1 | The write at mem_addr is allowed |

## Verification
The bench probes the protect boundaries on both sides: the last address below and the first address inside each region. A comparison that is off by one would either unlock the first protected byte or lock the last free one. Status writes carrying all-ones data test the hard-wired bits and the latch. A design that lets that data through would show a stray bit, or would set the latch without an enable. Transactions that enable, write and then deselect check the automatic clear. A design that clears on the wrong edge, or that never clears, would leave writes open into the next transaction. A memory write issued before the enable is also covered, and it must not arm the clear. Finally, commands sent with the chip select high must be ignored, which catches a decoder that does not gate on the select.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ENABLE  = 3'd1,
    OP_DISABLE = 3'd2,
    OP_RDSTAT  = 3'd3,
    OP_WRSTAT  = 3'd4,
    OP_MEMWR   = 3'd5
  } op_e;

  localparam int STAT_W   = 8;
  localparam int LATCH_IX = 1;
  localparam int PROT_LO  = 2;
  localparam int PROT_HI  = 3;

  // bits that never follow live state, and the values they carry
  localparam logic [STAT_W-1:0] HARD_MASK = 8'hF1;
  localparam logic [STAT_W-1:0] HARD_VAL  = 8'h40;

  typedef enum logic [1:0] {
    PROT_NONE  = 2'b00,
    PROT_QUART = 2'b01,
    PROT_HALF  = 2'b10,
    PROT_ALL   = 2'b11
  } prot_e;

endpackage

// File: rtl/sps_cmd_decode.sv
module sps_cmd_decode
  import sps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  output logic       do_set,
  output logic       do_clr,
  output logic       do_wrstat,
  output logic       do_memwr,
  output logic       sel_end
);

  logic cs_n_q;
  logic cs_n_d;
  logic active;

  always_comb begin
    cs_n_d = cs_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= 1'b1;
    end else begin
      cs_n_q <= cs_n_d;
    end
  end

  always_comb begin
    active    = cmd_valid & ~cs_n;
    do_set    = active & (cmd_op == OP_ENABLE);
    do_clr    = active & (cmd_op == OP_DISABLE);
    do_wrstat = active & (cmd_op == OP_WRSTAT);
    do_memwr  = active & (cmd_op == OP_MEMWR);
    sel_end   = cs_n & ~cs_n_q;
  end

endmodule

// File: rtl/sps_latch.sv
module sps_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic do_set,
  input  logic do_clr,
  input  logic do_wrstat,
  input  logic do_memwr,
  input  logic sel_end,
  output logic wel
);

  logic wel_q, wel_d;
  logic arm_q, arm_d;
  logic upd;

  // next-state: an end of select consumes the armed clear
  always_comb begin
    wel_d = wel_q;
    arm_d = arm_q;
    if (sel_end) begin
      if (arm_q) begin
        wel_d = 1'b0;
      end
      arm_d = 1'b0;
    end else begin
      if ((do_wrstat | do_memwr) & wel_q) begin
        arm_d = 1'b1;
      end
      if (do_set) begin
        wel_d = 1'b1;
      end
      if (do_clr) begin
        wel_d = 1'b0;
      end
    end
    upd = (wel_d != wel_q) | (arm_d != arm_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
      arm_q <= 1'b0;
    end else if (upd) begin
      wel_q <= wel_d;
      arm_q <= arm_d;
    end
  end

  assign wel = wel_q;

endmodule

// File: rtl/sps_protect_reg.sv
module sps_protect_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wel,
  input  logic       do_wrstat,
  input  logic [1:0] new_prot,
  output logic [1:0] prot
);

  logic [1:0] prot_q, prot_d;
  logic       load;

  always_comb begin
    load   = do_wrstat & wel;
    prot_d = new_prot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 2'b00;
    end else if (load) begin
      prot_q <= prot_d;
    end
  end

  assign prot = prot_q;

endmodule

// File: rtl/sps_range_check.sv
module sps_range_check
  import sps_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic [1:0]        prot,
  input  logic              wel,
  input  logic [ADDR_W-1:0] addr,
  output logic              permit
);

  localparam int TOP = ADDR_W - 1;

  logic locked;

  always_comb begin
    unique case (prot)
      PROT_NONE:  locked = 1'b0;
      PROT_QUART: locked = addr[TOP] & addr[TOP-1];
      PROT_HALF:  locked = addr[TOP];
      default:    locked = 1'b1;
    endcase
    permit = wel & ~locked;
  end

endmodule

// File: rtl/sps_status_guard.sv
module sps_status_guard
  import sps_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        status_o,
  output logic              permit_o
);

  logic       do_set, do_clr, do_wrstat, do_memwr, sel_end;
  logic       wel;
  logic [1:0] prot;
  logic [STAT_W-1:0] live;

  sps_cmd_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .do_set    (do_set),
    .do_clr    (do_clr),
    .do_wrstat (do_wrstat),
    .do_memwr  (do_memwr),
    .sel_end   (sel_end)
  );

  sps_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .do_set    (do_set),
    .do_clr    (do_clr),
    .do_wrstat (do_wrstat),
    .do_memwr  (do_memwr),
    .sel_end   (sel_end),
    .wel       (wel)
  );

  sps_protect_reg u_prot (
    .clk       (clk),
    .rst_n     (rst_n),
    .wel       (wel),
    .do_wrstat (do_wrstat),
    .new_prot  (wr_data[PROT_HI:PROT_LO]),
    .prot      (prot)
  );

  sps_range_check #(.ADDR_W(ADDR_W)) u_range (
    .prot   (prot),
    .wel    (wel),
    .addr   (mem_addr),
    .permit (permit_o)
  );

  always_comb begin
    live                   = '0;
    live[LATCH_IX]         = wel;
    live[PROT_HI:PROT_LO]  = prot;
  end

  // each status bit is either hard-wired or taken from live state
  for (genvar b = 0; b < STAT_W; b++) begin : g_stat
    if (HARD_MASK[b]) begin : g_hard
      assign status_o[b] = HARD_VAL[b];
    end else begin : g_live
      assign status_o[b] = live[b];
    end
  end

endmodule

// File: rtl/sps_status_guard_chk.sv
module sps_status_guard_chk
  import sps_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [7:0]        wr_data,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        status_o,
  input logic              permit_o
);

  logic act;
  assign act = cmd_valid & ~cs_n;

  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & HARD_MASK) == HARD_VAL);

  a_r3_set_latch: assert property (@(posedge clk) disable iff (!rst_n)
    act && cmd_op == OP_ENABLE |=> status_o[LATCH_IX]);

  a_r4_clear_latch: assert property (@(posedge clk) disable iff (!rst_n)
    act && cmd_op == OP_DISABLE |=> !status_o[LATCH_IX]);

  a_r5_locked_field: assert property (@(posedge clk) disable iff (!rst_n)
    act && cmd_op == OP_WRSTAT && !status_o[LATCH_IX]
      |=> $stable(status_o[PROT_HI:PROT_LO]));

  a_r6_wrstat_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
    act && cmd_op == OP_WRSTAT |=> $stable(status_o[LATCH_IX]));

  a_r8_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[PROT_HI:PROT_LO] == PROT_ALL |-> !permit_o);

  a_r9_permit_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    permit_o |-> status_o[LATCH_IX]);

  a_r10_idle_select: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) |=> $stable(status_o));

endmodule

bind sps_status_guard sps_status_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .wr_data   (wr_data),
  .mem_addr  (mem_addr),
  .status_o  (status_o),
  .permit_o  (permit_o)
);

// File: tb/sim_sps_status_guard.sv
`timescale 1ns/1ps
module sim_sps_status_guard;

  localparam int AW    = 15;
  localparam int DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          cs_n;
  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic [7:0]    wr_data;
  logic [AW-1:0] mem_addr;
  logic [7:0]    status_o;
  logic          permit_o;

  int    n_cmp;
  int    n_bad;
  string req;

  // behavioural reference state
  int m_wel, m_bp, m_arm, m_csq;

  sps_status_guard #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .wr_data(wr_data), .mem_addr(mem_addr),
    .status_o(status_o), .permit_o(permit_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wel = 0; m_bp = 0; m_arm = 0; m_csq = 1;
    end else begin
      if (cs_n && !m_csq) begin
        if (m_arm != 0) m_wel = 0;
        m_arm = 0;
      end else if (!cs_n && cmd_valid) begin
        if (cmd_op == 3'd4 && m_wel != 0) begin
          m_bp  = int'(wr_data[3:2]);
          m_arm = 1;
        end
        if (cmd_op == 3'd5 && m_wel != 0) m_arm = 1;
        if (cmd_op == 3'd1) m_wel = 1;
        if (cmd_op == 3'd2) m_wel = 0;
      end
      m_csq = cs_n ? 1 : 0;
    end
  end

  function automatic logic exp_permit(int a);
    int lim;
    case (m_bp)
      0: lim = DEPTH;
      1: lim = DEPTH * 3 / 4;
      2: lim = DEPTH / 2;
      default: lim = 0;
    endcase
    return (m_wel != 0) && (a < lim);
  endfunction

  task automatic compare();
    logic [7:0] es;
    logic       ep;
    es = 8'h40 | (m_wel != 0 ? 8'h02 : 8'h00) | 8'(m_bp << 2);
    ep = exp_permit(int'(mem_addr));
    n_cmp++;
    if (status_o !== es || permit_o !== ep) begin
      n_bad++;
      $display("FAIL %s: status=%h permit=%b, expected status=%h permit=%b (addr=%h)",
               req, status_o, permit_o, es, ep, mem_addr);
    end
  endtask

  // compare the settled outputs, then apply the next inputs
  task automatic step(input logic cs, input logic v, input logic [2:0] op,
                      input logic [7:0] d, input int a);
    @(negedge clk);
    compare();
    cs_n = cs; cmd_valid = v; cmd_op = op; wr_data = d; mem_addr = AW'(a);
  endtask

  task automatic idle(input int a);
    step(1'b0, 1'b0, 3'd0, 8'h00, a);
  endtask

  task automatic deselect();
    step(1'b1, 1'b0, 3'd0, 8'h00, 0);
    step(1'b1, 1'b0, 3'd0, 8'h00, 0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    int bounds[6];
    n_cmp = 0; n_bad = 0;
    bounds = '{0, DEPTH/2 - 1, DEPTH/2, DEPTH*3/4 - 1, DEPTH*3/4, DEPTH - 1};
    rst_n = 1'b0; cs_n = 1'b1; cmd_valid = 1'b0; cmd_op = 3'd0;
    wr_data = 8'h00; mem_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    req = "R1"; // reset state
    idle(DEPTH - 1); deselect();

    req = "R10"; // operations with select high are dropped
    step(1'b1, 1'b1, 3'd1, 8'h00, 5);
    step(1'b1, 1'b1, 3'd4, 8'hFF, 5);
    step(1'b1, 1'b0, 3'd0, 8'h00, 5);

    req = "R3"; // set latch, no write so it survives deselect
    step(1'b0, 1'b1, 3'd1, 8'h00, 0);
    idle(0); deselect(); idle(0);

    req = "R10"; // read and unused codes change nothing
    step(1'b0, 1'b1, 3'd3, 8'hFF, 0);
    step(1'b0, 1'b1, 3'd6, 8'hFF, 0);
    step(1'b0, 1'b1, 3'd7, 8'hFF, 0);
    idle(0);

    req = "R4"; // clear latch
    step(1'b0, 1'b1, 3'd2, 8'h00, 0);
    idle(0);

    req = "R5"; // status write while latch clear: ignored
    step(1'b0, 1'b1, 3'd4, 8'hFF, 0);
    idle(0); deselect();

    // R8 / R2: every protect code, boundary addresses on both sides
    for (int p = 0; p < 4; p++) begin
      req = "R8";
      step(1'b0, 1'b1, 3'd1, 8'h00, 0);
      step(1'b0, 1'b1, 3'd4, 8'hF3 & 8'({p[1:0], 2'b11} | 8'hF0) | 8'(p << 2), 0);
      for (int i = 0; i < 6; i++) idle(bounds[i]);
      req = "R7"; // accepted status write arms the clear
      deselect();
      req = "R9"; // latch now clear: nothing permitted
      for (int i = 0; i < 6; i++) idle(bounds[i]);
      deselect();
    end

    req = "R6"; // status write with bit 1 low keeps latch set
    step(1'b0, 1'b1, 3'd1, 8'h00, 0);
    step(1'b0, 1'b1, 3'd4, 8'h00, 0);
    idle(3);
    req = "R7"; deselect();

    req = "R7"; // memory write while enabled clears at deselect
    step(1'b0, 1'b1, 3'd1, 8'h00, 0);
    step(1'b0, 1'b1, 3'd5, 8'h00, 10);
    idle(10); deselect(); idle(10);

    req = "R7"; // memory write before enable does not arm the clear
    step(1'b0, 1'b1, 3'd5, 8'h00, 10);
    step(1'b0, 1'b1, 3'd1, 8'h00, 10);
    idle(10); deselect(); idle(10);
    step(1'b0, 1'b1, 3'd2, 8'h00, 0); deselect();

    req = "R2-random"; // mixed traffic; tags R2 R5 R6 R7 R8 R9 R10
    for (int k = 0; k < 3000; k++) begin
      logic cs;
      cs = ($urandom_range(0, 7) == 0);
      step(cs, 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
           8'($urandom), int'($urandom_range(0, DEPTH - 1)));
    end
    idle(0);
    finish_run();
  end

endmodule